// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Latched Event Flags

This block sits between an HDLC receive deframer and a processor. The deframer hands over one received byte per valid beat, marking the first byte of a message and the last byte of a message. Reaching the end marker means the message is over, whether it ended cleanly or was cut short by a check failure or an abort. The bytes go into a 64-entry queue. Each entry keeps a tag bit that says whether the byte opened a message, so the reader can see where messages begin.

Six conditions are turned into sticky event flags: the queue becoming non-empty, the level climbing above a programmable watermark, a message start arriving, a message end, a message-opening byte reaching the queue head, and an overrun. An overrun occurs when a byte arrives while all 64 entries are occupied. It ends the current message, and every later byte is thrown away until the next start marker. A small register port reads the flags, and the read clears them. The same port sets a per-flag interrupt enable mask and the watermark. The enabled flags are merged into one interrupt line.

Top module: `hdlc_rxq_evt`

## Requirements
- R1: After reset the queue is empty (`rd_empty`=1, `rd_level`=0), all event flags read 0, `irq` is 0, the enable mask (address 1) reads 0 and the watermark (address 2) reads 48.
- R2: Accepted bytes leave in arrival order. The queue head is shown on `rd_data` and `rd_first`, where `rd_first`=1 marks a byte written with `wr_som`. `rd_pop` removes the head, and `rd_level` counts the entries, up to 64.
- R3: A byte that is accepted while 64 entries are held is dropped and sets flag bit 5 (overrun) and flag bit 3 (message end). After that, bytes without `wr_som` are dropped even when space is free, and the next `wr_som` byte is taken normally.
- R4: Flag bit 4 is set when an entry tagged as a message opener becomes the queue head, either by arriving in an empty queue or by the pop of the entry before it.
- R5: Flag bit 3 is set when a byte with `wr_eom` is stored.
- R6: Flag bit 2 is set whenever a byte arrives with `wr_som`.
- R7: Flag bit 1 is set only on the transition of the condition "level strictly greater than the watermark" from false to true. The watermark is 6 bits wide and written at address 2.
- R8: Flag bit 0 is set on the transition of the queue from empty to non-empty.
- R9: The flags read at address 0 in bits 5..0, and bits 7 and 6 read 0. A read at address 0 clears every flag. A flag whose event occurs in the same cycle as the clearing read stays set. Address 3 reads 0.
- R10: `irq` is high exactly when some flag is set and its bit in the enable mask (address 1) is 1.
- R11: A pop request on an empty queue is ignored: the level stays 0 and the next byte written is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | A received byte is present this cycle |
| wr_data | input | 8 | Received byte |
| wr_som | input | 1 | Byte is the first of a message |
| wr_eom | input | 1 | Byte is the last of a message (good or faulted) |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_first | output | 1 | Head entry opened a message |
| rd_empty | output | 1 | Queue holds no entries |
| rd_level | output | 7 | Number of entries held |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (clears flags at address 0) |
| csr_addr | input | 2 | Register address: 0 flags, 1 enable mask, 2 watermark |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data, combinational from address |
| irq | output | 1 | Level interrupt, active high |

## Verification
The embedded assertions rely on a few properties of the inputs. The deframer presents at most one byte per cycle. Register reads and writes are single-cycle strobes. A pop is only taken when the queue holds data, so every push or drop decision is made on the level registered at the edge. The stimulus changes inputs only on the falling edge and holds each strobe for exactly one rising edge. It reads the flags one idle cycle after the traffic that causes them, except in the one case built to make an event coincide with a clearing read. It also sends pops into an empty queue on purpose, to show that they are ignored.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

    localparam int DEPTH_DEF = 64;
    localparam int DW_DEF    = 8;
    localparam int NEV       = 6;

    // Flag bit positions, as seen by software at address 0
    localparam int EV_NEMPTY = 0;
    localparam int EV_HWM    = 1;
    localparam int EV_PSTART = 2;
    localparam int EV_PEND   = 3;
    localparam int EV_OPEN   = 4;
    localparam int EV_OVR    = 5;

    typedef struct packed {
        logic ovr;
        logic open_byte;
        logic pkt_end;
        logic pkt_start;
        logic hwm;
        logic nempty;
    } hrq_events_t;

    typedef enum logic [1:0] {
        CSR_FLAGS = 2'd0,
        CSR_IEN   = 2'd1,
        CSR_WMARK = 2'd2,
        CSR_NONE  = 2'd3
    } hrq_csr_e;

    function automatic logic [DW_DEF-1:0] pad_flags(input hrq_events_t f);
        return {{(DW_DEF-NEV){1'b0}}, f};
    endfunction

endpackage

// File: rtl/hrq_fifo.sv
module hrq_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_entry,
    input  logic          pop_req,
    output logic [W-1:0]  head_entry,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          head_fresh,
    output logic          nempty_rise
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, prev_rd_ptr;
    logic [CW-1:0] cnt;
    logic          prev_empty;
    logic          do_pop;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign level  = cnt;
    assign do_pop = pop_req && !empty;
    assign head_entry = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr      <= '0;
            rd_ptr      <= '0;
            cnt         <= '0;
            prev_empty  <= 1'b1;
            prev_rd_ptr <= '0;
        end else begin
            if (push)   wr_ptr <= bump(wr_ptr);
            if (do_pop) rd_ptr <= bump(rd_ptr);
            case ({push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            prev_empty  <= empty;
            prev_rd_ptr <= rd_ptr;
        end
    end

    // A new entry reached the head since the previous cycle
    assign head_fresh  = !empty && (prev_empty || (rd_ptr != prev_rd_ptr));
    assign nempty_rise = !empty && prev_empty;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_pop_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_req && !push) |=> empty);

endmodule

// File: rtl/hrq_intake.sv
module hrq_intake #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_som,
    input  logic          wr_eom,
    input  logic          fifo_full,
    output logic          push,
    output logic [DW:0]   push_entry,
    output logic          ev_ovr,
    output logic          ev_pstart,
    output logic          ev_pend
);
    logic discard;
    logic accept;

    assign accept     = wr_valid && (!discard || wr_som);
    assign ev_ovr     = accept && fifo_full;
    assign push       = accept && !fifo_full;
    assign push_entry = {wr_som, wr_data};
    assign ev_pstart  = wr_valid && wr_som;
    assign ev_pend    = (push && wr_eom) || ev_ovr;

    always_ff @(posedge clk) begin
        if (rst)                    discard <= 1'b0;
        else if (ev_ovr)            discard <= 1'b1;
        else if (wr_valid && wr_som) discard <= 1'b0;
    end

    p_discard_after_ovr_r3: assert property (@(posedge clk) disable iff (rst)
        ev_ovr |=> discard);
    p_no_push_while_discard_r3: assert property (@(posedge clk) disable iff (rst)
        (discard && !wr_som) |-> !push);

endmodule

// File: rtl/hrq_evtlat.sv
module hrq_evtlat #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] status,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (clr ? '0 : status) | set_ev;
    end

    assign irq = |(status & en);

    p_set_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (set_ev != '0) |=> ((status & $past(set_ev)) == $past(set_ev)));
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && set_ev == '0) |=> (status == '0));
    p_irq_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && set_ev == '0) |=> !irq);

endmodule

// File: rtl/hdlc_rxq_evt.sv
module hdlc_rxq_evt
    import hrq_pkg::*;
#(
    parameter int DEPTH     = DEPTH_DEF,
    parameter int DW        = DW_DEF,
    parameter int WMARK_RST = 48,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int WMW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_som,
    input  logic          wr_eom,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data,
    output logic          rd_first,
    output logic          rd_empty,
    output logic [CW-1:0] rd_level,
    input  logic          csr_wr,
    input  logic          csr_rd,
    input  logic [1:0]    csr_addr,
    input  logic [7:0]    csr_wdata,
    output logic [7:0]    csr_rdata,
    output logic          irq
);
    logic          push, full, head_fresh, nempty_rise;
    logic [DW:0]   push_entry, head_entry;
    logic          ev_ovr, ev_pstart, ev_pend;
    logic [WMW-1:0] wmark;
    logic [7:0]    ien;
    logic          above, above_prev;
    hrq_events_t   ev, flags;
    logic          clr;
    hrq_csr_e      sel;

    hrq_intake #(.DW(DW)) u_intake (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_som(wr_som), .wr_eom(wr_eom),
        .fifo_full(full), .push(push), .push_entry(push_entry),
        .ev_ovr(ev_ovr), .ev_pstart(ev_pstart), .ev_pend(ev_pend)
    );

    hrq_fifo #(.DEPTH(DEPTH), .W(DW + 1)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .push_entry(push_entry), .pop_req(rd_pop),
        .head_entry(head_entry), .level(rd_level), .empty(rd_empty), .full(full),
        .head_fresh(head_fresh), .nempty_rise(nempty_rise)
    );

    assign rd_data  = head_entry[DW-1:0];
    assign rd_first = head_entry[DW];

    assign above = rd_level > CW'(wmark);

    always_ff @(posedge clk) begin
        if (rst) begin
            wmark      <= WMW'(WMARK_RST);
            ien        <= '0;
            above_prev <= 1'b0;
        end else begin
            above_prev <= above;
            if (csr_wr && sel == CSR_IEN)   ien   <= csr_wdata;
            if (csr_wr && sel == CSR_WMARK) wmark <= csr_wdata[WMW-1:0];
        end
    end

    always_comb begin
        ev           = '0;
        ev.ovr       = ev_ovr;
        ev.open_byte = head_fresh && rd_first;
        ev.pkt_end   = ev_pend;
        ev.pkt_start = ev_pstart;
        ev.hwm       = above && !above_prev;
        ev.nempty    = nempty_rise;
    end

    assign sel = hrq_csr_e'(csr_addr);
    assign clr = csr_rd && (sel == CSR_FLAGS);

    hrq_evtlat #(.N(NEV)) u_evt (
        .clk(clk), .rst(rst),
        .set_ev(ev), .clr(clr), .en(ien[NEV-1:0]),
        .status(flags), .irq(irq)
    );

    always_comb begin
        case (sel)
            CSR_FLAGS: csr_rdata = pad_flags(flags);
            CSR_IEN:   csr_rdata = ien;
            CSR_WMARK: csr_rdata = 8'(wmark);
            default:   csr_rdata = '0;
        endcase
    end

    p_hwm_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (above && above_prev) |=> (flags.hwm == $past(flags.hwm) || $past(clr)));

endmodule

// File: tb/hdlc_rxq_evt_tb_top.sv
`timescale 1ns/1ps
module hdlc_rxq_evt_tb_top;
    logic clk = 1'b0;
    logic rst;
    logic wr_valid, wr_som, wr_eom, rd_pop, csr_wr, csr_rd;
    logic [7:0] wr_data, csr_wdata, csr_rdata, rd_data;
    logic [1:0] csr_addr;
    logic rd_first, rd_empty, irq;
    logic [6:0] rd_level;

    always #2.5 clk = ~clk;

    hdlc_rxq_evt dut_i (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_som(wr_som), .wr_eom(wr_eom),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_first(rd_first),
        .rd_empty(rd_empty), .rd_level(rd_level),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [8:0] sb[$];
    int  m_cnt = 0;
    bit  m_disc = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: model acceptance, push expected entries into the scoreboard
    task automatic put(input logic [7:0] d, input bit som, input bit eom);
        bit acc;
        acc = !m_disc || som;
        if (acc && m_cnt == 64)       m_disc = 1;
        else begin
            if (som) m_disc = 0;
            if (acc) begin
                sb.push_back({som, d});
                m_cnt++;
            end
        end
        wr_valid = 1; wr_data = d; wr_som = som; wr_eom = eom;
        @(negedge clk);
        wr_valid = 0; wr_som = 0; wr_eom = 0;
    endtask

    task automatic pop();
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
        if (m_cnt > 0) m_cnt--;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [7:0] v);
        csr_rd = 1; csr_addr = a;
        #1 v = csr_rdata;
        @(negedge clk);
        csr_rd = 0;
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [7:0] v);
        csr_wr = 1; csr_addr = a; csr_wdata = v;
        @(negedge clk);
        csr_wr = 0;
    endtask

    task automatic flags_expect(input string req, input int exp);
        logic [7:0] v;
        idle();
        csr_read(2'd0, v);
        chk(req, v, exp);
    endtask

    // Monitor: compares every popped head against the scoreboard, just before the edge
    always begin
        @(negedge clk);
        #1.5;
        if (rd_pop) begin
            if (sb.size() > 0) begin
                logic [8:0] e;
                e = sb.pop_front();
                chk("R2 head data", rd_data, e[7:0]);
                chk("R2 head first tag", rd_first, e[8]);
            end else begin
                chk("R11 pop on empty sees empty", rd_empty, 1);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        rst = 1; wr_valid = 0; wr_data = 0; wr_som = 0; wr_eom = 0;
        rd_pop = 0; csr_wr = 0; csr_rd = 0; csr_addr = 0; csr_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 empty", rd_empty, 1);
        chk("R1 level", rd_level, 0);
        chk("R1 irq", irq, 0);
        csr_read(2'd0, v); chk("R1 flags", v, 0);
        csr_read(2'd1, v); chk("R1 enable mask", v, 0);
        csr_read(2'd2, v); chk("R1 watermark", v, 48);
        csr_read(2'd3, v); chk("R9 unused address", v, 0);

        // Three-byte message: R4 R5 R6 R8
        put(8'hA1, 1, 0); put(8'hB2, 0, 0); put(8'hC3, 0, 1);
        flags_expect("R4 R5 R6 R8 message flags", 8'h1D);
        flags_expect("R9 cleared by read", 8'h00);
        chk("R2 level three", rd_level, 3);
        repeat (3) pop();
        chk("R2 drained", rd_empty, 1);

        // Watermark R7
        csr_write(2'd2, 8'd4);
        for (int i = 0; i < 5; i++) put(8'(8'h10 + i), i == 0, 0);
        flags_expect("R7 crossing sets bit1", 8'h17);
        put(8'h20, 0, 0);
        flags_expect("R7 no new edge while above", 8'h00);
        repeat (6) pop();
        flags_expect("R7 drain leaves no flag", 8'h00);

        // Interrupt masking R10
        put(8'h33, 1, 1);
        idle();
        chk("R10 masked irq low", irq, 0);
        csr_write(2'd1, 8'h08);
        chk("R10 enabled flag raises irq", irq, 1);
        csr_read(2'd0, v);
        chk("R10 irq low after clear", irq, 0);
        csr_write(2'd1, 8'h00);
        pop();

        // Opening byte at head after pops R4
        put(8'h41, 1, 0); put(8'h42, 0, 1); put(8'h43, 1, 0);
        flags_expect("R4 setup clear", 8'h1D);
        pop();
        flags_expect("R4 non-opener at head", 8'h00);
        pop();
        flags_expect("R4 opener reaches head", 8'h10);
        pop();
        flags_expect("R8 back to empty", 8'h00);

        // Overrun R3
        csr_write(2'd2, 8'd63);
        for (int i = 0; i < 64; i++) put(8'(i), i == 0, 0);
        put(8'hEE, 0, 0);
        flags_expect("R3 overrun and end flags", 8'h3F);
        chk("R3 level full", rd_level, 64);
        pop();
        put(8'hDD, 0, 0);
        flags_expect("R3 discarded byte no flags", 8'h00);
        chk("R3 discarded byte not stored", rd_level, 63);
        put(8'h77, 1, 0);
        flags_expect("R3 start resumes intake", 8'h06);
        chk("R3 level after resume", rd_level, 64);
        repeat (64) pop();
        chk("R2 empty after drain", rd_empty, 1);
        flags_expect("R3 clear after drain", 8'h10);

        // Event coinciding with clearing read R9
        put(8'h5C, 1, 1);
        csr_read(2'd0, v);
        chk("R9 read before late events", v, 8'h0C);
        flags_expect("R9 coinciding events kept", 8'h11);
        pop();

        // Pop on empty R11
        pop(); pop();
        chk("R11 level stays zero", rd_level, 0);
        put(8'h5A, 1, 1);
        idle();
        pop();
        chk("R11 empty at end", rd_empty, 1);
        idle();
        summary();
    end
endmodule